// File: doc/BRIEF.md
# Prescaled PWM Input Capture Unit

This block measures an external pulse-width-modulated signal against a free-running timebase. The input is brought into the clock domain through a synchronizer, and its rising and falling edges are detected. Two capture channels share the timebase. The rise channel latches the timebase on rising edges and gives the period reference. The fall channel latches it on falling edges and gives the high time. Each channel has its own edge prescaler, so that at high input rates a capture happens only once every 1, 2, 4 or 8 qualifying edges. Each capture produces a one-cycle request pulse that a DMA engine or an interrupt line can consume.

The timebase restarts on every rise capture, so each rise capture value is the elapsed cycle count directly. The unit also derives the single-period length and the high time from the two capture registers. When the two prescalers run out of phase, which happens if the unit is enabled while the input is high, the fall capture spans almost the whole prescaled window. The duty output then applies a correction so that it still gives the single-period high time.

Configuration is a single write strobe that loads the enable bit, both prescale codes and the timebase limit together.

Top module: `pwm_capture_unit`

## Requirements
- R1: After reset, and in the cycle after any configuration write, `rise_valid`, `fall_valid`, `overflow`, `rise_req` and `fall_req` are 0. A write also restarts the timebase at 0 and clears both prescaler edge counters.
- R2: With the unit enabled, prescale code N (0, 1, 2, 3) makes a channel capture on every 2^N-th qualifying edge, counted from the first such edge after the last configuration write. While disabled, edges cause no capture and no request.
- R3: The rise channel acts only on rising input edges and the fall channel only on falling ones. Each request is a single-cycle pulse in the same cycle that its capture register takes a new value.
- R4: An input level change sampled at clock edge k produces its capture and request after clock edge k+2.
- R5: A rise capture holds the number of clock cycles since the previous rise capture. The first capture after a configuration write at edge w, taken at edge e, holds e-w-1. A fall capture holds the cycles since the last rise capture, counted on the same timebase. The timebase reads 1 in the cycle after a rise capture.
- R6: Each capture register keeps its value except on its own channel's prescaled event. Its valid flag goes to 1 with the first such event after a configuration write.
- R7: The timebase stops at the programmed limit (values of 2 or more). Reaching the limit in a cycle without a rise capture sets `overflow`, which stays set until the next configuration write. Captured values never exceed the limit.
- R8: `meas_period` equals `rise_capture` shifted right by the rise prescale code.
- R9: Let P = `meas_period`. If `fall_capture` is at least P, `meas_duty` = P - (`rise_capture` - `fall_capture`), taken modulo 2^CNT_W. Otherwise `meas_duty` = `fall_capture`.
- R10: A configuration write that changes the prescale codes during a running input discards edges already counted, so the next capture comes after a full 2^N new edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Asynchronous PWM signal under measurement |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable value loaded on a write |
| cfg_psc_rise | input | 2 | Rise channel prescale code (0..3) |
| cfg_psc_fall | input | 2 | Fall channel prescale code (0..3) |
| cfg_limit | input | CNT_W | Timebase limit loaded on a write |
| rise_capture | output | CNT_W | Rise channel capture register |
| rise_valid | output | 1 | Rise channel has captured since the last write |
| rise_req | output | 1 | One-cycle rise capture request |
| fall_capture | output | CNT_W | Fall channel capture register |
| fall_valid | output | 1 | Fall channel has captured since the last write |
| fall_req | output | 1 | One-cycle fall capture request |
| overflow | output | 1 | Sticky timebase limit flag |
| meas_period | output | CNT_W | Single-period length derived from the rise capture |
| meas_duty | output | CNT_W | High time derived from both captures |

## Verification
The unit is tried with pulse trains that start on a rising edge after enable, which keeps the prescalers in phase, and with trains that start while the input is high, which puts them out of phase. Both cases must give the same duty, so a missing or wrong correction shows up. A held-still input with a small limit separates the overflow and saturation path from the capture path. A disabled run and a code change in the middle of a train show whether edges are ignored and whether the prescaler counts are discarded. Random periods, duties, codes and limits are compared every cycle against a reference model that follows the latency rule, so an off-by-one in the prescalers or in the timebase restart is caught.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int PSC_CODE_W = 2;
  localparam int PSC_CNT_W  = 3;
  localparam int NUM_CH     = 2;
  localparam int CH_RISE    = 0;
  localparam int CH_FALL    = 1;

  typedef logic [PSC_CODE_W-1:0] psc_code_t;

  typedef struct packed {
    logic      enable;
    psc_code_t rise_code;
    psc_code_t fall_code;
  } pcu_mode_t;

  // Edge count at which a prescaler wraps: 2^code - 1
  function automatic logic [PSC_CNT_W-1:0] psc_wrap_value(psc_code_t code);
    logic [PSC_CNT_W:0] span;
    span = (PSC_CNT_W+1)'(1) << code;
    return PSC_CNT_W'(span - 1'b1);
  endfunction

  // Single period from a prescaled span
  function automatic logic [31:0] single_period(logic [31:0] span, psc_code_t code);
    return span >> code;
  endfunction

  // High time, corrected when the falling channel runs out of phase
  function automatic logic [31:0] high_time(logic [31:0] span_rise,
                                            logic [31:0] span_fall,
                                            psc_code_t   code);
    logic [31:0] one;
    one = single_period(span_rise, code);
    if (span_fall >= one) return one - (span_rise - span_fall);
    return span_fall;
  endfunction

endpackage

// File: rtl/pcu_sync_edge.sv
module pcu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], sig_in};
      prev_q  <= chain_q[LAST];
    end
  end

  assign rise_o =  chain_q[LAST] & ~prev_q;
  assign fall_o = ~chain_q[LAST] &  prev_q;
endmodule

// File: rtl/pcu_edge_prescaler.sv
module pcu_edge_prescaler
  import pcu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear_i,
  input  logic      edge_i,
  input  psc_code_t code_i,
  output logic      fire_o
);
  logic [PSC_CNT_W-1:0] cnt_q;
  logic                 at_wrap;

  assign at_wrap = (cnt_q == psc_wrap_value(code_i));
  assign fire_o  = edge_i & at_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (edge_i)  cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcu_timebase.sv
module pcu_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_limit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign at_limit_o = (cnt_q == limit_i);
  assign count_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (run_i) begin
      if (restart_i)       cnt_q <= CNT_W'(1);
      else if (!at_limit_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcu_capture_reg.sv
module pcu_capture_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] value_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             valid_o,
  output logic             req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o   <= '0;
      valid_o <= 1'b0;
      req_o   <= 1'b0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      req_o <= fire_i;
      if (fire_i) begin
        cap_o   <= value_i;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_capture_unit.sv
module pwm_capture_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_psc_rise,
  input  logic [1:0]       cfg_psc_fall,
  input  logic [CNT_W-1:0] cfg_limit,
  output logic [CNT_W-1:0] rise_capture,
  output logic             rise_valid,
  output logic             rise_req,
  output logic [CNT_W-1:0] fall_capture,
  output logic             fall_valid,
  output logic             fall_req,
  output logic             overflow,
  output logic [CNT_W-1:0] meas_period,
  output logic [CNT_W-1:0] meas_duty
);
  // Configuration state, loaded as one unit
  pcu_mode_t        mode_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      limit_q <= '1;
    end else if (cfg_we) begin
      mode_q.enable    <= cfg_enable;
      mode_q.rise_code <= cfg_psc_rise;
      mode_q.fall_code <= cfg_psc_fall;
      limit_q          <= cfg_limit;
    end
  end

  // Named internal events
  logic             edge_rise, edge_fall;
  logic             run;
  logic             rise_evt, fall_evt;
  logic [CNT_W-1:0] tb_count;
  logic             tb_at_limit;

  assign run = mode_q.enable & ~cfg_we;

  pcu_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(pwm_in),
    .rise_o(edge_rise), .fall_o(edge_fall)
  );

  // Per-channel prescaler and capture register
  logic             ch_edge [NUM_CH];
  psc_code_t        ch_code [NUM_CH];
  logic             ch_fire [NUM_CH];
  logic [CNT_W-1:0] ch_cap  [NUM_CH];
  logic             ch_valid[NUM_CH];
  logic             ch_req  [NUM_CH];

  assign ch_edge[CH_RISE] = edge_rise & run;
  assign ch_edge[CH_FALL] = edge_fall & run;
  assign ch_code[CH_RISE] = mode_q.rise_code;
  assign ch_code[CH_FALL] = mode_q.fall_code;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pcu_edge_prescaler i_psc (
      .clk(clk), .rst_n(rst_n), .clear_i(cfg_we),
      .edge_i(ch_edge[c]), .code_i(ch_code[c]), .fire_o(ch_fire[c])
    );
    pcu_capture_reg #(.CNT_W(CNT_W)) i_cap (
      .clk(clk), .rst_n(rst_n), .clear_i(cfg_we),
      .fire_i(ch_fire[c]), .value_i(tb_count),
      .cap_o(ch_cap[c]), .valid_o(ch_valid[c]), .req_o(ch_req[c])
    );
  end

  assign rise_evt = ch_fire[CH_RISE];
  assign fall_evt = ch_fire[CH_FALL];

  pcu_timebase #(.CNT_W(CNT_W)) i_tb (
    .clk(clk), .rst_n(rst_n), .clear_i(cfg_we), .run_i(run),
    .restart_i(rise_evt), .limit_i(limit_q),
    .count_o(tb_count), .at_limit_o(tb_at_limit)
  );

  // Sticky overflow: limit reached without a period capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   overflow <= 1'b0;
    else if (cfg_we)                              overflow <= 1'b0;
    else if (run && tb_at_limit && !rise_evt)     overflow <= 1'b1;
  end

  assign rise_capture = ch_cap[CH_RISE];
  assign rise_valid   = ch_valid[CH_RISE];
  assign rise_req     = ch_req[CH_RISE];
  assign fall_capture = ch_cap[CH_FALL];
  assign fall_valid   = ch_valid[CH_FALL];
  assign fall_req     = ch_req[CH_FALL];

  // Derived measurement
  logic [31:0] per_w, duty_w;
  assign per_w       = single_period(32'(rise_capture), mode_q.rise_code);
  assign duty_w      = high_time(32'(rise_capture), 32'(fall_capture), mode_q.rise_code);
  assign meas_period = per_w[CNT_W-1:0];
  assign meas_duty   = duty_w[CNT_W-1:0];
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             rise_req,
  input logic             fall_req,
  input logic             rise_valid,
  input logic             fall_valid,
  input logic [CNT_W-1:0] rise_capture,
  input logic [CNT_W-1:0] fall_capture,
  input logic             overflow,
  input logic [CNT_W-1:0] tb_count,
  input logic [CNT_W-1:0] limit_q
);
  assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_req && fall_req));

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_req |=> !rise_req);

  assert_rise_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_req |-> $stable(rise_capture));

  assert_fall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_req |-> $stable(fall_capture));

  assert_valid_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_valid) |-> rise_req);

  assert_cfg_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!rise_valid && !fall_valid && !overflow && !rise_req && !fall_req));

  assert_no_overflow_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cfg_we) |=> overflow);

  assert_cap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_req |-> (rise_capture <= limit_q));

  assert_tb_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_req |-> (tb_count == CNT_W'(1)));
endmodule

bind pwm_capture_unit pcu_checker #(.CNT_W(CNT_W)) i_pcu_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .rise_req(rise_req), .fall_req(fall_req),
  .rise_valid(rise_valid), .fall_valid(fall_valid),
  .rise_capture(rise_capture), .fall_capture(fall_capture),
  .overflow(overflow), .tb_count(tb_count), .limit_q(limit_q)
);

// File: tb/test_pwm_capture_unit.sv
module test_pwm_capture_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, pwm_in = 1'b0;
  logic cfg_we = 1'b0, cfg_enable = 1'b0;
  logic [1:0] cfg_psc_rise = '0, cfg_psc_fall = '0;
  logic [W-1:0] cfg_limit = '0;
  logic [W-1:0] rise_capture, fall_capture, meas_period, meas_duty;
  logic rise_valid, rise_req, fall_valid, fall_req, overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_capture_unit #(.CNT_W(W)) i_pwm_capture_unit (.*);

  int checks = 0, fails = 0, req_seen = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ref_period(logic [W-1:0] span, logic [1:0] code);
    return span / (W'(1) << code);
  endfunction

  function automatic logic [W-1:0] ref_duty(logic [W-1:0] rc, logic [W-1:0] fc, logic [1:0] code);
    logic [W-1:0] p, low;
    p = ref_period(rc, code);
    low = rc - fc;
    return (fc < p) ? fc : W'(p - low);
  endfunction

  // Reference model: input seen at clock edge k acts after edge k+2 (R4)
  bit m_prev, m_en, m_rv, m_fv, m_ovf, m_rreq, m_freq;
  logic [1:0] dr, df, m_cr, m_cf;
  logic [W-1:0] m_tb, m_rcap, m_fcap, m_lim;
  int m_rc, m_fc;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_prev = 0; dr = 0; df = 0; m_en = 0; m_cr = 0; m_cf = 0; m_lim = '1;
      m_tb = 0; m_rcap = 0; m_fcap = 0; m_rc = 0; m_fc = 0;
      m_rv = 0; m_fv = 0; m_ovf = 0; m_rreq = 0; m_freq = 0;
    end else begin
      bit cur, ar, af, rf, ff;
      logic [W-1:0] t;
      cur = pwm_in;
      ar = dr[1]; af = df[1];
      dr = {dr[0], cur & ~m_prev};
      df = {df[0], ~cur & m_prev};
      m_prev = cur;
      m_rreq = 0; m_freq = 0;
      if (cfg_we) begin
        m_en = cfg_enable; m_cr = cfg_psc_rise; m_cf = cfg_psc_fall; m_lim = cfg_limit;
        m_tb = 0; m_rc = 0; m_fc = 0; m_rv = 0; m_fv = 0; m_ovf = 0;
      end else if (m_en) begin
        t = m_tb; rf = 0; ff = 0;
        if (ar) begin
          if (m_rc == (1 << m_cr) - 1) begin rf = 1; m_rc = 0; end else m_rc++;
        end
        if (af) begin
          if (m_fc == (1 << m_cf) - 1) begin ff = 1; m_fc = 0; end else m_fc++;
        end
        if (rf) begin m_rcap = t; m_rv = 1; m_rreq = 1; m_tb = 1; end
        else if (t == m_lim) m_ovf = 1;
        else m_tb = t + 1'b1;
        if (ff) begin m_fcap = t; m_fv = 1; m_freq = 1; end
      end
      if (rise_req) req_seen++;
      if (!done) begin
        check("R2 rise_req", rise_req, m_rreq);
        check("R3 fall_req", fall_req, m_freq);
        check("R5 rise_capture", rise_capture, m_rcap);
        check("R5 fall_capture", fall_capture, m_fcap);
        check("R6 valid flags", {rise_valid, fall_valid}, {m_rv, m_fv});
        check("R7 overflow", overflow, m_ovf);
        check("R8 meas_period", meas_period, ref_period(m_rcap, m_cr));
        check("R9 meas_duty", meas_duty, ref_duty(m_rcap, m_fcap, m_cr));
      end
    end
  end

  // Stimulus helpers: every task starts and ends just after a falling clock edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cfg_write(bit en, logic [1:0] cr, logic [1:0] cf, logic [W-1:0] lim);
    cfg_enable = en; cfg_psc_rise = cr; cfg_psc_fall = cf; cfg_limit = lim;
    cfg_we = 1'b1;
    idle(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_train(int p, int h, int n);
    for (int i = 0; i < n; i++) begin
      pwm_in = 1'b1; idle(h);
      pwm_in = 1'b0; idle(p - h);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    check("R1 reset flags", {rise_valid, fall_valid, overflow, rise_req, fall_req}, 5'b0);

    // R4: latency with code 0
    cfg_write(1, 0, 0, 16'd1000);
    idle(3);
    pwm_in = 1'b1;
    idle(1); check("R4 no req after k", rise_req, 0);
    idle(1); check("R4 no req after k+1", rise_req, 0);
    idle(1); check("R4 req after k+2", rise_req, 1);
    pwm_in = 1'b0; idle(6);

    // R9: in-phase start, code 2 on both channels
    cfg_write(1, 2, 2, 16'd1000);
    idle(2);
    pulse_train(10, 3, 12);
    idle(6);
    check("R8 in-phase period", meas_period, 10);
    check("R9 in-phase duty", meas_duty, 3);

    // R9: out-of-phase start (enabled while input high)
    pwm_in = 1'b1; idle(5);
    cfg_write(1, 2, 2, 16'd1000);
    idle(2);
    pwm_in = 1'b0; idle(4);
    pulse_train(9, 5, 12);
    idle(6);
    check("R9 out-of-phase fall span", fall_capture, 3*9 + 5);
    check("R8 out-of-phase period", meas_period, 9);
    check("R9 out-of-phase duty", meas_duty, 5);

    // R2: disabled unit ignores edges
    cfg_write(0, 0, 0, 16'd1000);
    req_seen = 0;
    pulse_train(6, 2, 5);
    idle(4);
    check("R2 disabled no capture", {rise_valid, fall_valid}, 2'b00);
    check("R2 disabled no request", req_seen, 0);

    // R2: code 1 captures every second rise
    cfg_write(1, 1, 1, 16'd1000);
    idle(2); req_seen = 0;
    pulse_train(8, 3, 6);
    idle(4);
    check("R2 code1 request count", req_seen, 3);

    // R10: code change mid-run drops counted edges
    cfg_write(1, 1, 1, 16'd1000);
    idle(2);
    pulse_train(8, 3, 3);
    cfg_write(1, 2, 2, 16'd1000);
    req_seen = 0;
    pulse_train(8, 3, 3);
    idle(3);
    check("R10 no capture before 4th edge", req_seen, 0);
    pulse_train(8, 3, 1);
    idle(1);
    check("R10 capture on 4th edge", req_seen, 1);

    // R7: overflow on a still input, sticky, cleared by write (R1)
    cfg_write(1, 0, 0, 16'd20);
    idle(40);
    check("R7 overflow set", overflow, 1);
    check("R7 no capture yet", rise_valid, 0);
    pulse_train(10, 4, 5);
    idle(4);
    check("R7 overflow sticky", overflow, 1);
    cfg_write(1, 0, 0, 16'd20);
    check("R1 write clears overflow", overflow, 0);

    // Random phase: model compares every cycle
    for (int it = 0; it < 40; it++) begin
      int p, h, n;
      pwm_in = $urandom_range(1, 0);
      idle($urandom_range(4, 1));
      cfg_write($urandom_range(9, 0) != 0, 2'($urandom_range(3, 0)), 2'($urandom_range(3, 0)),
                W'($urandom_range(300, 8)));
      idle($urandom_range(3, 0));
      p = $urandom_range(30, 2);
      h = $urandom_range(p - 1, 1);
      n = $urandom_range(20, 2);
      pulse_train(p, h, n);
      idle($urandom_range(12, 3));
    end
    finish_run();
  end
endmodule